// File: doc/BRIEF.md
# Frequent Pattern Word and Line Codec

This block compresses the 32-bit words of a cache line. It gives each word a 3-bit class code and a payload whose width depends on the class. A word that is all zeros or all ones needs only the code. A word made of four copies of one byte keeps a single byte. A word with one zero half keeps the other half. Any other word keeps all 32 bits. A decoder turns a code and its payload back into the original word. A line packer takes a whole line of words, lays the codes end to end into one bit string and reports how many bits the string uses.

The three paths are independent and each has one register stage. A result appears on the cycle after its input, together with a valid flag that follows the input valid flag. A payload is right-aligned in its 32-bit field, and every bit above its length is zero. In a packed line, word 0 begins at bit 0. Each word's code sits in the low 3 bits of its slot and its payload follows directly above.

Top module: `fpc_codec`

## Requirements
- R1: A zero word encodes as class 3'b000 with payload length 0 and payload 0.
- R2: The word 0xFFFFFFFF encodes as class 3'b100 with payload length 0, even though it also has four equal bytes.
- R3: A word with four equal bytes that is neither all zeros nor all ones encodes as 3'b011. Its payload is that byte in bits [7:0] and its length is 8.
- R4: A word not covered by R1 to R3 whose bits [31:16] are zero encodes as 3'b001. Its payload is bits [15:0] and its length is 16.
- R5: A word not covered by R1 to R4 whose bits [15:0] are zero encodes as 3'b010. Its payload is bits [31:16], placed in payload bits [15:0], and its length is 16.
- R6: Any other word encodes as 3'b111 with the whole word as payload and length 32.
- R7: Payload bits at and above the reported length are always zero.
- R8: For classes 000, 001, 010, 011, 100 and 111, the decoder rebuilds the original word from the class code and the right-aligned payload, with the error flag low.
- R9: Classes 3'b101 and 3'b110 are reserved. The decoder raises its error flag for them and outputs a zero word.
- R10: The line packer reports a total of the sum over 16 words of (3 + payload length). The total lies between 48 and 560.
- R11: In the packed line string, word i's code starts at bit (sum over words j<i of (3 + length j)). The class code is in the low 3 bits of each slot, the payload is directly above it, and all bits at and above the total are zero.
- R12: Each result and its valid flag appear exactly one clock after the input. While reset is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid_i | input | 1 | Word to encode is present |
| enc_word_i | input | 32 | Word to encode |
| enc_valid_o | output | 1 | Encoder result valid |
| enc_prefix_o | output | 3 | Class code |
| enc_payload_o | output | 32 | Right-aligned payload |
| enc_len_o | output | 6 | Payload length in bits |
| dec_valid_i | input | 1 | Code to decode is present |
| dec_prefix_i | input | 3 | Class code to decode |
| dec_payload_i | input | 32 | Right-aligned payload to decode |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_word_o | output | 32 | Rebuilt word |
| dec_err_o | output | 1 | Reserved class code received |
| line_valid_i | input | 1 | Line to pack is present |
| line_words_i | input | 512 | 16 words, word i in bits [32i+31:32i] |
| line_valid_o | output | 1 | Packed line valid |
| line_bits_o | output | 10 | Total packed length in bits |
| line_code_o | output | 560 | Packed code string |

## Verification
The assertions check on every cycle the properties that hold for any input. They cover zeroed payload bits above the length, the fixed lengths that go with each class code, the zero word on a reserved-code error, the range of the line total, and the one-cycle valid timing. The class priority, the exact payload contents, the decoder round trip and the bit layout of a packed line depend on the particular data. Only the bench's vectors and its computed line strings can show those.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int WORD_W  = 32;
    localparam int PFX_W   = 3;
    localparam int LEN_W   = 6;
    localparam int CODE_W  = WORD_W + PFX_W;

    typedef enum logic [PFX_W-1:0] {
        PFX_ZERO   = 3'b000,
        PFX_LOWKEP = 3'b001,
        PFX_HIKEEP = 3'b010,
        PFX_BYTE   = 3'b011,
        PFX_ONES   = 3'b100,
        PFX_RSV_A  = 3'b101,
        PFX_RSV_B  = 3'b110,
        PFX_RAW    = 3'b111
    } fpc_class_e;
endpackage

// File: rtl/fpc_word_classify.sv
module fpc_word_classify
    import fpc_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [PFX_W-1:0]  prefix_o,
    output logic [WORD_W-1:0] payload_o,
    output logic [LEN_W-1:0]  len_o
);
    localparam int HALF_W = WORD_W / 2;
    localparam int NBYTES = WORD_W / 8;

    logic is_zero, is_ones, is_rep, hi_zero, lo_zero;

    always_comb begin
        is_rep = 1'b1;
        for (int b = 1; b < NBYTES; b++) begin
            if (word_i[b*8 +: 8] != word_i[7:0]) is_rep = 1'b0;
        end
    end

    assign is_zero = (word_i == '0);
    assign is_ones = (&word_i);
    assign hi_zero = (word_i[WORD_W-1:HALF_W] == '0);
    assign lo_zero = (word_i[HALF_W-1:0] == '0);

    always_comb begin
        prefix_o  = PFX_RAW;
        payload_o = word_i;
        len_o     = LEN_W'(WORD_W);
        if (is_zero) begin
            prefix_o  = PFX_ZERO;
            payload_o = '0;
            len_o     = '0;
        end else if (is_ones) begin
            prefix_o  = PFX_ONES;
            payload_o = '0;
            len_o     = '0;
        end else if (is_rep) begin
            prefix_o  = PFX_BYTE;
            payload_o = {{(WORD_W-8){1'b0}}, word_i[7:0]};
            len_o     = LEN_W'(8);
        end else if (hi_zero) begin
            prefix_o  = PFX_LOWKEP;
            payload_o = {{HALF_W{1'b0}}, word_i[HALF_W-1:0]};
            len_o     = LEN_W'(HALF_W);
        end else if (lo_zero) begin
            prefix_o  = PFX_HIKEEP;
            payload_o = {{HALF_W{1'b0}}, word_i[WORD_W-1:HALF_W]};
            len_o     = LEN_W'(HALF_W);
        end
    end
endmodule

// File: rtl/fpc_word_expand.sv
module fpc_word_expand
    import fpc_pkg::*;
(
    input  logic [PFX_W-1:0]  prefix_i,
    input  logic [WORD_W-1:0] payload_i,
    output logic [WORD_W-1:0] word_o,
    output logic              err_o
);
    localparam int HALF_W = WORD_W / 2;
    localparam int NBYTES = WORD_W / 8;

    always_comb begin
        word_o = '0;
        err_o  = 1'b0;
        case (fpc_class_e'(prefix_i))
            PFX_ZERO:   word_o = '0;
            PFX_LOWKEP: word_o = {{HALF_W{1'b0}}, payload_i[HALF_W-1:0]};
            PFX_HIKEEP: word_o = {payload_i[HALF_W-1:0], {HALF_W{1'b0}}};
            PFX_BYTE:   word_o = {NBYTES{payload_i[7:0]}};
            PFX_ONES:   word_o = '1;
            PFX_RAW:    word_o = payload_i;
            default:    err_o  = 1'b1;
        endcase
    end
endmodule

// File: rtl/fpc_line_pack.sv
module fpc_line_pack
    import fpc_pkg::*;
#(
    parameter int LINE_WORDS = 16,
    localparam int LCW = LINE_WORDS * CODE_W,
    localparam int LBW = $clog2(LCW + 1)
) (
    input  logic [LINE_WORDS*WORD_W-1:0] words_i,
    output logic [LBW-1:0]               bits_o,
    output logic [LCW-1:0]               code_o
);
    logic [PFX_W-1:0]  pfx_a [LINE_WORDS];
    logic [WORD_W-1:0] pay_a [LINE_WORDS];
    logic [LEN_W-1:0]  len_a [LINE_WORDS];

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
        fpc_word_classify u_cls (
            .word_i   (words_i[g*WORD_W +: WORD_W]),
            .prefix_o (pfx_a[g]),
            .payload_o(pay_a[g]),
            .len_o    (len_a[g])
        );
    end

    always_comb begin
        logic [LBW-1:0] off;
        logic [LCW-1:0] acc;
        off = '0;
        acc = '0;
        for (int i = 0; i < LINE_WORDS; i++) begin
            acc = acc | ({{(LCW-CODE_W){1'b0}}, pay_a[i], pfx_a[i]} << off);
            off = off + LBW'(PFX_W) + LBW'(len_a[i]);
        end
        bits_o = off;
        code_o = acc;
    end
endmodule

// File: rtl/fpc_codec.sv
module fpc_codec
    import fpc_pkg::*;
#(
    parameter int LINE_WORDS = 16,
    localparam int LCW = LINE_WORDS * CODE_W,
    localparam int LBW = $clog2(LCW + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enc_valid_i,
    input  logic [WORD_W-1:0]            enc_word_i,
    output logic                         enc_valid_o,
    output logic [PFX_W-1:0]             enc_prefix_o,
    output logic [WORD_W-1:0]            enc_payload_o,
    output logic [LEN_W-1:0]             enc_len_o,
    input  logic                         dec_valid_i,
    input  logic [PFX_W-1:0]             dec_prefix_i,
    input  logic [WORD_W-1:0]            dec_payload_i,
    output logic                         dec_valid_o,
    output logic [WORD_W-1:0]            dec_word_o,
    output logic                         dec_err_o,
    input  logic                         line_valid_i,
    input  logic [LINE_WORDS*WORD_W-1:0] line_words_i,
    output logic                         line_valid_o,
    output logic [LBW-1:0]               line_bits_o,
    output logic [LCW-1:0]               line_code_o
);
    typedef struct packed {
        logic              enc_v;
        logic [PFX_W-1:0]  enc_pfx;
        logic [WORD_W-1:0] enc_pay;
        logic [LEN_W-1:0]  enc_len;
        logic              dec_v;
        logic [WORD_W-1:0] dec_word;
        logic              dec_err;
        logic              line_v;
        logic [LBW-1:0]    line_bits;
        logic [LCW-1:0]    line_code;
    } stage_t;

    stage_t st_d, st_q;

    logic [PFX_W-1:0]  c_pfx;
    logic [WORD_W-1:0] c_pay;
    logic [LEN_W-1:0]  c_len;
    logic [WORD_W-1:0] x_word;
    logic              x_err;
    logic [LBW-1:0]    p_bits;
    logic [LCW-1:0]    p_code;

    fpc_word_classify u_enc (
        .word_i   (enc_word_i),
        .prefix_o (c_pfx),
        .payload_o(c_pay),
        .len_o    (c_len)
    );

    fpc_word_expand u_dec (
        .prefix_i (dec_prefix_i),
        .payload_i(dec_payload_i),
        .word_o   (x_word),
        .err_o    (x_err)
    );

    fpc_line_pack #(.LINE_WORDS(LINE_WORDS)) u_pack (
        .words_i(line_words_i),
        .bits_o (p_bits),
        .code_o (p_code)
    );

    always_comb begin
        st_d           = st_q;
        st_d.enc_v     = enc_valid_i;
        st_d.dec_v     = dec_valid_i;
        st_d.line_v    = line_valid_i;
        if (enc_valid_i) begin
            st_d.enc_pfx = c_pfx;
            st_d.enc_pay = c_pay;
            st_d.enc_len = c_len;
        end
        if (dec_valid_i) begin
            st_d.dec_word = x_word;
            st_d.dec_err  = x_err;
        end
        if (line_valid_i) begin
            st_d.line_bits = p_bits;
            st_d.line_code = p_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enc_valid_o   = st_q.enc_v;
    assign enc_prefix_o  = st_q.enc_pfx;
    assign enc_payload_o = st_q.enc_pay;
    assign enc_len_o     = st_q.enc_len;
    assign dec_valid_o   = st_q.dec_v;
    assign dec_word_o    = st_q.dec_word;
    assign dec_err_o     = st_q.dec_err;
    assign line_valid_o  = st_q.line_v;
    assign line_bits_o   = st_q.line_bits;
    assign line_code_o   = st_q.line_code;
endmodule

// File: rtl/fpc_codec_chk.sv
module fpc_codec_chk
    import fpc_pkg::*;
#(
    parameter int LINE_WORDS = 16,
    localparam int LCW = LINE_WORDS * CODE_W,
    localparam int LBW = $clog2(LCW + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         enc_valid_i,
    input logic [WORD_W-1:0]            enc_word_i,
    input logic                         enc_valid_o,
    input logic [PFX_W-1:0]             enc_prefix_o,
    input logic [WORD_W-1:0]            enc_payload_o,
    input logic [LEN_W-1:0]             enc_len_o,
    input logic                         dec_valid_i,
    input logic [PFX_W-1:0]             dec_prefix_i,
    input logic [WORD_W-1:0]            dec_payload_i,
    input logic                         dec_valid_o,
    input logic [WORD_W-1:0]            dec_word_o,
    input logic                         dec_err_o,
    input logic                         line_valid_i,
    input logic [LINE_WORDS*WORD_W-1:0] line_words_i,
    input logic                         line_valid_o,
    input logic [LBW-1:0]               line_bits_o,
    input logic [LCW-1:0]               line_code_o
);
    a_r7_payload_clean: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> ((enc_payload_o >> enc_len_o) == '0));

    a_r2_fixed_class_len: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid_o && (enc_prefix_o == PFX_ZERO || enc_prefix_o == PFX_ONES))
            |-> (enc_len_o == '0));

    a_r6_raw_len: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid_o && enc_prefix_o == PFX_RAW) |-> (enc_len_o == LEN_W'(WORD_W)));

    a_r3_no_reserved_out: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> (enc_prefix_o != PFX_RSV_A && enc_prefix_o != PFX_RSV_B));

    a_r9_err_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_err_o) |-> (dec_word_o == '0));

    a_r10_total_range: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_o |-> (line_bits_o >= LBW'(LINE_WORDS*PFX_W)
                          && line_bits_o <= LBW'(LCW)));

    a_r12_enc_latency: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);

    a_r12_dec_latency: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);

    a_r12_line_latency: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid_i |=> !line_valid_o);
endmodule

bind fpc_codec fpc_codec_chk #(.LINE_WORDS(LINE_WORDS)) u_chk (.*);

// File: tb/fpc_codec_test.sv
module fpc_codec_test;
    localparam int NW  = 16;
    localparam int LCW = NW * 35;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_valid_i = 1'b0;
    logic [31:0] enc_word_i = '0;
    logic enc_valid_o;
    logic [2:0] enc_prefix_o;
    logic [31:0] enc_payload_o;
    logic [5:0] enc_len_o;
    logic dec_valid_i = 1'b0;
    logic [2:0] dec_prefix_i = '0;
    logic [31:0] dec_payload_i = '0;
    logic dec_valid_o;
    logic [31:0] dec_word_o;
    logic dec_err_o;
    logic line_valid_i = 1'b0;
    logic [NW*32-1:0] line_words_i = '0;
    logic line_valid_o;
    logic [9:0] line_bits_o;
    logic [LCW-1:0] line_code_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    fpc_codec #(.LINE_WORDS(NW)) uut (.*);

    // word, class, payload, length
    localparam logic [72:0] VEC [13] = '{
        {32'h00000000, 3'b000, 32'h00000000, 6'd0},
        {32'hFFFFFFFF, 3'b100, 32'h00000000, 6'd0},
        {32'h5A5A5A5A, 3'b011, 32'h0000005A, 6'd8},
        {32'h80808080, 3'b011, 32'h00000080, 6'd8},
        {32'h01010101, 3'b011, 32'h00000001, 6'd8},
        {32'h0000ABCD, 3'b001, 32'h0000ABCD, 6'd16},
        {32'h00000001, 3'b001, 32'h00000001, 6'd16},
        {32'h0000FFFF, 3'b001, 32'h0000FFFF, 6'd16},
        {32'h12340000, 3'b010, 32'h00001234, 6'd16},
        {32'h00FF0000, 3'b010, 32'h000000FF, 6'd16},
        {32'hFFFF0000, 3'b010, 32'h0000FFFF, 6'd16},
        {32'hABCDEFFF, 3'b111, 32'hABCDEFFF, 6'd32},
        {32'hFFFFFFFE, 3'b111, 32'hFFFFFFFE, 6'd32}
    };

    function automatic string tag_of(input logic [2:0] p);
        case (p)
            3'b000: return "R1";
            3'b100: return "R2";
            3'b011: return "R3";
            3'b001: return "R4";
            3'b010: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [LCW-1:0] act, input logic [LCW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference encoder built from R1..R6
    task automatic ref_enc(input logic [31:0] w, output logic [2:0] p,
                           output logic [31:0] pay, output int len);
        if (w == 32'h0) begin p = 3'b000; pay = 0; len = 0; end
        else if (w == 32'hFFFFFFFF) begin p = 3'b100; pay = 0; len = 0; end
        else if (w == {4{w[7:0]}}) begin p = 3'b011; pay = {24'h0, w[7:0]}; len = 8; end
        else if (w[31:16] == 16'h0) begin p = 3'b001; pay = {16'h0, w[15:0]}; len = 16; end
        else if (w[15:0] == 16'h0) begin p = 3'b010; pay = {16'h0, w[31:16]}; len = 16; end
        else begin p = 3'b111; pay = w; len = 32; end
    endtask

    task automatic line_test(input logic [NW*32-1:0] words, input string name);
        logic [LCW-1:0] exp_code;
        int off;
        exp_code = '0;
        off = 0;
        for (int i = 0; i < NW; i++) begin
            logic [2:0] p;
            logic [31:0] pay;
            int len;
            ref_enc(words[i*32 +: 32], p, pay, len);
            for (int b = 0; b < 3; b++) exp_code[off + b] = p[b];
            for (int b = 0; b < len; b++) exp_code[off + 3 + b] = pay[b];
            off += 3 + len;
        end
        @(negedge clk);
        line_words_i = words;
        line_valid_i = 1'b1;
        @(negedge clk);
        line_valid_i = 1'b0;
        check("R12", {name, " line valid"}, LCW'(line_valid_o), LCW'(1));
        check("R10", {name, " total bits"}, LCW'(line_bits_o), LCW'(off));
        check("R11", {name, " packed string"}, line_code_o, exp_code);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [NW*32-1:0] lw;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "enc valid in reset", LCW'(enc_valid_o), '0);
        check("R12", "dec valid in reset", LCW'(dec_valid_o), '0);
        check("R12", "line outputs in reset", LCW'(line_bits_o) | line_code_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "enc idle after reset", LCW'(enc_valid_o), '0);

        // table walk: encoder, and decoder round trip in the same cycle
        for (int k = 0; k < 13; k++) begin
            logic [31:0] w, pay;
            logic [2:0]  p;
            logic [5:0]  l;
            {w, p, pay, l} = VEC[k];
            enc_word_i = w;
            enc_valid_i = 1'b1;
            dec_prefix_i = p;
            dec_payload_i = pay;
            dec_valid_i = 1'b1;
            @(negedge clk);
            check(tag_of(p), "class", LCW'(enc_prefix_o), LCW'(p));
            check("R7", "payload", LCW'(enc_payload_o), LCW'(pay));
            check(tag_of(p), "length", LCW'(enc_len_o), LCW'(l));
            check("R12", "enc valid", LCW'(enc_valid_o), LCW'(1));
            check("R8", "decoded word", LCW'(dec_word_o), LCW'(w));
            check("R8", "decode error flag", LCW'(dec_err_o), '0);
        end
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        @(negedge clk);
        check("R12", "enc valid drops", LCW'(enc_valid_o), '0);

        // R9: reserved codes
        for (int r = 5; r <= 6; r++) begin
            dec_prefix_i = 3'(r);
            dec_payload_i = 32'hDEADBEEF;
            dec_valid_i = 1'b1;
            @(negedge clk);
            check("R9", "reserved error flag", LCW'(dec_err_o), LCW'(1));
            check("R9", "reserved word", LCW'(dec_word_o), '0);
        end
        dec_valid_i = 1'b0;

        // R10/R11: line packing
        line_test('0, "all zero");
        line_test('1, "all ones");
        for (int i = 0; i < NW; i++) lw[i*32 +: 32] = 32'h12345678 + 32'(i * 3);
        line_test(lw, "all raw");
        for (int i = 0; i < NW; i++) lw[i*32 +: 32] = VEC[i % 13][72:41];
        line_test(lw, "mixed");
        @(negedge clk);
        check("R12", "line valid drops", LCW'(line_valid_o), '0);

        // R12: reset after activity
        enc_word_i = 32'h0000ABCD;
        enc_valid_i = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", "reset clears enc valid", LCW'(enc_valid_o), '0);
        check("R12", "reset clears payload", LCW'(enc_payload_o), '0);
        enc_valid_i = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule